// File: doc/BRIEF.md
# Receive Buffer Descriptor Closer

This block sits behind a byte-oriented receiver and places each incoming byte into the buffer named by the current entry of a small ring of receive descriptors. It counts the bytes written into the current buffer. It decides when that buffer must be handed back to software. A buffer is closed when any of four conditions holds: the byte count reaches the programmed maximum message length, a receive error is flagged, the buffer fills up, or software issues a hunt command.

On every close the block writes back a 16-bit status word and the number of bytes the buffer received. It returns ownership of the descriptor by clearing its empty bit and pulses an interrupt if that interrupt is unmasked. It then moves on to the next descriptor in the ring. Software owns the top four status bits (empty, external, wrap, interrupt enable) and loads them, together with a 24-bit buffer pointer, through a simple descriptor write port. If the descriptor the block has moved to is not marked empty, the block reports busy and drops everything that arrives until software re-arms that descriptor.

Top module: `rxbd_closer`

## Requirements
- R1: When an accepted byte brings the count of the current buffer to `max_len`, the buffer closes with the last flag (status bit 11) set and a length equal to `max_len`; a `max_len` of 0 never causes a close.
- R2: A pulse on `rx_crc_err`, `rx_ovr_err` or `rx_cd_lost` closes the buffer with the last flag set and the matching flag in status bit 2, 1 or 0; a byte accepted in the same cycle is written and counted in the length.
- R3: When an accepted byte brings the count to `buf_size`, the buffer closes as full; the last flag stays clear unless the maximum length is reached in the same cycle.
- R4: A `hunt` pulse closes the buffer with the last flag and all error flags clear, reporting the bytes received so far (a byte accepted in the same cycle included), even when that count is 0.
- R5: One cycle after a close, `st_we` pulses for one cycle with `st_idx` naming the closed descriptor, `st_word` holding bit 15 = 0, bits 14..12 copied from that descriptor's external, wrap and interrupt-enable bits, bit 11 = last, bits 10..3 = 0 and bits 2..0 = error flags, and `st_len` holding the byte count; close causes in the same cycle merge into one write-back.
- R6: `irq` pulses in the same cycle as `st_we` exactly when the closed descriptor's interrupt-enable bit and `irq_en` were both 1 in the closing cycle.
- R7: After a close the next descriptor is index 0 if the closed one had its wrap bit set or was the last index of the ring, and the index plus one otherwise; the byte count restarts at 0.
- R8: `busy` is 1 whenever the current descriptor's empty bit is 0; while busy, bytes, error pulses and hunt pulses produce no memory write and no close.
- R9: Each accepted byte is written one cycle later with `mem_we` = 1, `mem_addr` = buffer pointer + byte offset in the buffer (modulo 2^24) and `mem_wdata` = the byte.
- R10: A descriptor write (`bd_we`) stores the four user bits and the pointer of entry `bd_idx`; after reset every empty bit is 0, the ring index is 0, `busy` is 1 and all strobes are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bd_we | input | 1 | Descriptor write strobe |
| bd_idx | input | 2 | Descriptor index to write |
| bd_empty | input | 1 | Empty bit (buffer handed to the block) |
| bd_ext | input | 1 | External bit, reported back unchanged |
| bd_wrap | input | 1 | Wrap bit, next descriptor is index 0 |
| bd_ienb | input | 1 | Interrupt enable for this descriptor |
| bd_ptr | input | 24 | Buffer base pointer |
| max_len | input | 16 | Maximum message length, 0 disables |
| buf_size | input | 16 | Buffer size in bytes |
| irq_en | input | 1 | Global interrupt mask, 1 = enabled |
| rx_valid | input | 1 | Received byte valid |
| rx_data | input | 8 | Received byte |
| rx_crc_err | input | 1 | CRC error pulse |
| rx_ovr_err | input | 1 | Overrun pulse |
| rx_cd_lost | input | 1 | Carrier detect lost pulse |
| hunt | input | 1 | Enter-hunt command pulse |
| mem_we | output | 1 | Buffer data write strobe |
| mem_addr | output | 24 | Buffer data write address |
| mem_wdata | output | 8 | Buffer data write byte |
| st_we | output | 1 | Status write-back strobe |
| st_idx | output | 2 | Index of the descriptor written back |
| st_word | output | 16 | Status word written back |
| st_len | output | 16 | Data length written back |
| irq | output | 1 | Interrupt pulse |
| busy | output | 1 | Current descriptor not owned by the block |

## Verification
The sharpest coincidence is a byte that completes the maximum length or fills the buffer arriving in the very cycle an error or hunt pulse comes in, so two close causes and a data write meet on one edge. The bench sweeps every event kind across every byte position, including the positions where the count meets `max_len` or `buf_size`, for a grid of small sizes. It requires exactly one write-back whose flags are the union of the causes and whose length counts that final byte, together with the data write of that byte to the closing buffer rather than the next one.

// File: rtl/rxbd_pkg.sv
package rxbd_pkg;

  // User-owned control bits of one descriptor
  typedef struct packed {
    logic empty;
    logic ext;
    logic wrap;
    logic ienb;
  } bd_ctrl_t;

  // Error causes latched into the status word
  typedef struct packed {
    logic crc;
    logic ovr;
    logic cdl;
  } rx_err_t;

  localparam int STAT_W = 16;

  // Assemble the written-back status: ownership returned (bit 15 = 0)
  function automatic logic [STAT_W-1:0] make_status(bd_ctrl_t c, logic last, rx_err_t e);
    logic [STAT_W-1:0] s;
    s     = '0;
    s[14] = c.ext;
    s[13] = c.wrap;
    s[12] = c.ienb;
    s[11] = last;
    s[2]  = e.crc;
    s[1]  = e.ovr;
    s[0]  = e.cdl;
    return s;
  endfunction

endpackage

// File: rtl/rxbd_table.sv
module rxbd_table
  import rxbd_pkg::*;
#(
  parameter int NUM_BD = 4,
  parameter int ADDR_W = 24,
  localparam int IDX_W = (NUM_BD > 1) ? $clog2(NUM_BD) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              host_we,
  input  logic [IDX_W-1:0]  host_idx,
  input  bd_ctrl_t          host_ctrl,
  input  logic [ADDR_W-1:0] host_ptr,
  input  logic              give_back,
  input  logic [IDX_W-1:0]  give_idx,
  input  logic [IDX_W-1:0]  rd_idx,
  output bd_ctrl_t          rd_ctrl,
  output logic [ADDR_W-1:0] rd_ptr
);

  bd_ctrl_t          ctrl_q  [NUM_BD];
  logic [ADDR_W-1:0] ptr_mem [NUM_BD];

  // Pointer store: write-only from the host, no reset, RAM-inferable
  always_ff @(posedge clk) begin
    if (host_we) ptr_mem[host_idx] <= host_ptr;
  end

  // Control bits: the block clears empty on close; a host write to the
  // same entry in the same cycle is issued later and wins
  always_ff @(posedge clk) begin
    if (rst) begin
      for (int k = 0; k < NUM_BD; k++) ctrl_q[k] <= '0;
    end else begin
      if (give_back) ctrl_q[give_idx].empty <= 1'b0;
      if (host_we)   ctrl_q[host_idx]       <= host_ctrl;
    end
  end

  assign rd_ctrl = ctrl_q[rd_idx];
  assign rd_ptr  = ptr_mem[rd_idx];

endmodule

// File: rtl/rxbd_counter.sv
module rxbd_counter #(
  parameter int LEN_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             accept,
  input  logic             err_any,
  input  logic             hunt_ok,
  input  logic [LEN_W-1:0] max_len,
  input  logic [LEN_W-1:0] buf_size,
  output logic [LEN_W-1:0] count_q,
  output logic [LEN_W-1:0] len_out,
  output logic             hit_max,
  output logic             hit_full,
  output logic             close
);

  logic [LEN_W-1:0] cnt_nxt;

  always_comb begin
    cnt_nxt  = count_q + LEN_W'(accept);
    hit_max  = accept && (max_len != '0) && (cnt_nxt == max_len);
    hit_full = accept && (cnt_nxt == buf_size);
    close    = hit_max || hit_full || err_any || hunt_ok;
    len_out  = cnt_nxt;
  end

  always_ff @(posedge clk) begin
    if (rst)        count_q <= '0;
    else if (close) count_q <= '0;
    else            count_q <= cnt_nxt;
  end

endmodule

// File: rtl/rxbd_wb.sv
module rxbd_wb
  import rxbd_pkg::*;
#(
  parameter int ADDR_W = 24,
  parameter int LEN_W  = 16,
  parameter int DATA_W = 8,
  parameter int IDX_W  = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              accept,
  input  logic [DATA_W-1:0] rx_data,
  input  logic [ADDR_W-1:0] base,
  input  logic [LEN_W-1:0]  offset,
  input  logic              close,
  input  logic              last,
  input  rx_err_t           errs,
  input  bd_ctrl_t          ctrl,
  input  logic [IDX_W-1:0]  idx,
  input  logic [LEN_W-1:0]  len,
  input  logic              irq_en,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  output logic              st_we,
  output logic [IDX_W-1:0]  st_idx,
  output logic [STAT_W-1:0] st_word,
  output logic [LEN_W-1:0]  st_len,
  output logic              irq
);

  always_ff @(posedge clk) begin
    if (rst) begin
      mem_we    <= 1'b0;
      mem_addr  <= '0;
      mem_wdata <= '0;
      st_we     <= 1'b0;
      st_idx    <= '0;
      st_word   <= '0;
      st_len    <= '0;
      irq       <= 1'b0;
    end else begin
      mem_we <= accept;
      if (accept) begin
        mem_addr  <= base + ADDR_W'(offset);
        mem_wdata <= rx_data;
      end
      st_we <= close;
      irq   <= close && ctrl.ienb && irq_en;
      if (close) begin
        st_idx  <= idx;
        st_word <= make_status(ctrl, last, errs);
        st_len  <= len;
      end
    end
  end

endmodule

// File: rtl/rxbd_closer.sv
module rxbd_closer
  import rxbd_pkg::*;
#(
  parameter int NUM_BD = 4,
  parameter int ADDR_W = 24,
  parameter int LEN_W  = 16,
  parameter int DATA_W = 8,
  localparam int IDX_W = (NUM_BD > 1) ? $clog2(NUM_BD) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bd_we,
  input  logic [IDX_W-1:0]  bd_idx,
  input  logic              bd_empty,
  input  logic              bd_ext,
  input  logic              bd_wrap,
  input  logic              bd_ienb,
  input  logic [ADDR_W-1:0] bd_ptr,
  input  logic [LEN_W-1:0]  max_len,
  input  logic [LEN_W-1:0]  buf_size,
  input  logic              irq_en,
  input  logic              rx_valid,
  input  logic [DATA_W-1:0] rx_data,
  input  logic              rx_crc_err,
  input  logic              rx_ovr_err,
  input  logic              rx_cd_lost,
  input  logic              hunt,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  output logic              st_we,
  output logic [IDX_W-1:0]  st_idx,
  output logic [STAT_W-1:0] st_word,
  output logic [LEN_W-1:0]  st_len,
  output logic              irq,
  output logic              busy
);

  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_BD - 1);

  logic [IDX_W-1:0]  cur_idx;
  bd_ctrl_t          cur_ctrl;
  bd_ctrl_t          host_ctrl;
  logic [ADDR_W-1:0] cur_ptr;
  logic              accept, err_any, hunt_ok, close;
  logic              hit_max, hit_full;
  logic [LEN_W-1:0]  count_q, len_out;
  rx_err_t           errs;

  assign host_ctrl = '{empty: bd_empty, ext: bd_ext, wrap: bd_wrap, ienb: bd_ienb};

  // Ownership gate: nothing is taken while the current entry is not empty
  assign busy    = ~cur_ctrl.empty;
  assign accept  = rx_valid & ~busy;
  assign errs    = busy ? '0 : '{crc: rx_crc_err, ovr: rx_ovr_err, cdl: rx_cd_lost};
  assign err_any = |errs;
  assign hunt_ok = hunt & ~busy;

  rxbd_table #(
    .NUM_BD (NUM_BD),
    .ADDR_W (ADDR_W)
  ) u_table (
    .clk       (clk),
    .rst       (rst),
    .host_we   (bd_we),
    .host_idx  (bd_idx),
    .host_ctrl (host_ctrl),
    .host_ptr  (bd_ptr),
    .give_back (close),
    .give_idx  (cur_idx),
    .rd_idx    (cur_idx),
    .rd_ctrl   (cur_ctrl),
    .rd_ptr    (cur_ptr)
  );

  rxbd_counter #(
    .LEN_W (LEN_W)
  ) u_counter (
    .clk      (clk),
    .rst      (rst),
    .accept   (accept),
    .err_any  (err_any),
    .hunt_ok  (hunt_ok),
    .max_len  (max_len),
    .buf_size (buf_size),
    .count_q  (count_q),
    .len_out  (len_out),
    .hit_max  (hit_max),
    .hit_full (hit_full),
    .close    (close)
  );

  rxbd_wb #(
    .ADDR_W (ADDR_W),
    .LEN_W  (LEN_W),
    .DATA_W (DATA_W),
    .IDX_W  (IDX_W)
  ) u_wb (
    .clk       (clk),
    .rst       (rst),
    .accept    (accept),
    .rx_data   (rx_data),
    .base      (cur_ptr),
    .offset    (count_q),
    .close     (close),
    .last      (hit_max | err_any),
    .errs      (errs),
    .ctrl      (cur_ctrl),
    .idx       (cur_idx),
    .len       (len_out),
    .irq_en    (irq_en),
    .mem_we    (mem_we),
    .mem_addr  (mem_addr),
    .mem_wdata (mem_wdata),
    .st_we     (st_we),
    .st_idx    (st_idx),
    .st_word   (st_word),
    .st_len    (st_len),
    .irq       (irq)
  );

  // Ring advance; full closes are observable through the status word only
  always_ff @(posedge clk) begin
    if (rst) begin
      cur_idx <= '0;
    end else if (close) begin
      if (cur_ctrl.wrap || cur_idx == LAST_IDX) cur_idx <= '0;
      else                                      cur_idx <= cur_idx + 1'b1;
    end
  end

  logic unused_full;
  assign unused_full = hit_full;

endmodule

// File: rtl/rxbd_closer_chk.sv
module rxbd_closer_chk #(
  parameter int NUM_BD = 4,
  parameter int LEN_W  = 16,
  localparam int IDX_W = (NUM_BD > 1) ? $clog2(NUM_BD) : 1
) (
  input logic             clk,
  input logic             rst,
  input logic             busy,
  input logic             rx_valid,
  input logic             hunt,
  input logic [LEN_W-1:0] max_len,
  input logic             mem_we,
  input logic             st_we,
  input logic [IDX_W-1:0] st_idx,
  input logic [15:0]      st_word,
  input logic [LEN_W-1:0] st_len,
  input logic             irq,
  input logic [IDX_W-1:0] cur_idx
);

  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_BD - 1);

  p_irq_with_wb_r6: assert property (@(posedge clk) disable iff (rst)
    irq |-> st_we);

  p_irq_needs_ienb_r6: assert property (@(posedge clk) disable iff (rst)
    irq |-> st_word[12]);

  p_busy_drops_r8: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(busy) && $past(rx_valid)) |-> !mem_we);

  p_write_source_r9: assert property (@(posedge clk) disable iff (rst)
    mem_we |-> ($past(rx_valid) && !$past(busy)));

  p_hunt_closes_r4: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(hunt) && !$past(busy)) |-> st_we);

  p_ring_next_r7: assert property (@(posedge clk) disable iff (rst)
    st_we |-> (cur_idx == ((st_word[13] || st_idx == LAST_IDX) ? '0 : st_idx + 1'b1)));

  p_max_len_r1: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && st_we && st_word[11] && st_word[2:0] == 3'b000) |-> (st_len == $past(max_len)));

endmodule

bind rxbd_closer rxbd_closer_chk #(
  .NUM_BD (NUM_BD),
  .LEN_W  (LEN_W)
) u_chk (
  .clk      (clk),
  .rst      (rst),
  .busy     (busy),
  .rx_valid (rx_valid),
  .hunt     (hunt),
  .max_len  (max_len),
  .mem_we   (mem_we),
  .st_we    (st_we),
  .st_idx   (st_idx),
  .st_word  (st_word),
  .st_len   (st_len),
  .irq      (irq),
  .cur_idx  (cur_idx)
);

// File: tb/rxbd_closer_bench.sv
module rxbd_closer_bench;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bd_we = 1'b0;
  logic [1:0]  bd_idx = '0;
  logic        bd_empty = 1'b0, bd_ext = 1'b0, bd_wrap = 1'b0, bd_ienb = 1'b0;
  logic [23:0] bd_ptr = '0;
  logic [15:0] max_len = '0, buf_size = '0;
  logic        irq_en = 1'b1;
  logic        rx_valid = 1'b0;
  logic [7:0]  rx_data = '0;
  logic        rx_crc_err = 1'b0, rx_ovr_err = 1'b0, rx_cd_lost = 1'b0, hunt = 1'b0;
  logic        mem_we, st_we, irq, busy;
  logic [23:0] mem_addr;
  logic [7:0]  mem_wdata;
  logic [1:0]  st_idx;
  logic [15:0] st_word, st_len;

  rxbd_closer u_rxbd_closer (
    .clk(clk), .rst(rst), .bd_we(bd_we), .bd_idx(bd_idx), .bd_empty(bd_empty),
    .bd_ext(bd_ext), .bd_wrap(bd_wrap), .bd_ienb(bd_ienb), .bd_ptr(bd_ptr),
    .max_len(max_len), .buf_size(buf_size), .irq_en(irq_en), .rx_valid(rx_valid),
    .rx_data(rx_data), .rx_crc_err(rx_crc_err), .rx_ovr_err(rx_ovr_err),
    .rx_cd_lost(rx_cd_lost), .hunt(hunt), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .st_we(st_we), .st_idx(st_idx), .st_word(st_word),
    .st_len(st_len), .irq(irq), .busy(busy)
  );

  always #4 clk = ~clk;  // 125 MHz

  int n_checks = 0;
  int n_fails  = 0;

  // Reference state, built from the requirements
  int m_e[4], m_x[4], m_w[4], m_i[4], m_ptr[4];
  int m_idx = 0;
  int m_cnt = 0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic report();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
  endtask

  initial begin
    #(8 * 190000);
    n_checks++;
    n_fails++;
    $display("FAIL watchdog expired actual=0x0 expected=0x1");
    report();
    $finish;
  end

  // Host descriptor write, one cycle, no receive activity
  task automatic bd_write(input int idx, input int e, input int x, input int w, input int i, input int p);
    bd_we = 1'b1; bd_idx = 2'(idx);
    bd_empty = 1'(e); bd_ext = 1'(x); bd_wrap = 1'(w); bd_ienb = 1'(i);
    bd_ptr = 24'(p);
    @(posedge clk);
    @(negedge clk);
    bd_we = 1'b0;
    m_e[idx] = e; m_x[idx] = x; m_w[idx] = w; m_i[idx] = i; m_ptr[idx] = p;
  endtask

  // One receive cycle: drive, predict, clock, compare
  task automatic step(input bit v, input int d, input bit crc, input bit ovr, input bit cd, input bit hu);
    bit bsy, acc, ea, ho, hmax, hfull, cl, last;
    int nxt, wexp, eaddr, idx;
    string ctag;
    idx = m_idx;
    rx_valid = v; rx_data = 8'(d);
    rx_crc_err = crc; rx_ovr_err = ovr; rx_cd_lost = cd; hunt = hu;
    bsy = (m_e[idx] == 0);
    chk(busy == bsy, "R8 busy level", int'(busy), int'(bsy));
    acc  = v && !bsy;
    ea   = (crc || ovr || cd) && !bsy;
    ho   = hu && !bsy;
    nxt  = m_cnt + int'(acc);
    hmax = acc && (max_len != 0) && (nxt == int'(max_len));
    hfull = acc && (nxt == int'(buf_size));
    cl   = hmax || hfull || ea || ho;
    last = hmax || ea;
    eaddr = (m_ptr[idx] + m_cnt) & 24'hFFFFFF;
    wexp = (m_x[idx] << 14) | (m_w[idx] << 13) | (m_i[idx] << 12) | (int'(last) << 11);
    if (!bsy) wexp = wexp | (int'(crc) << 2) | (int'(ovr) << 1) | int'(cd);
    if (ho)        ctag = "R4 hunt close length";
    else if (ea)   ctag = "R2 error close length";
    else if (hmax) ctag = "R1 max length close length";
    else           ctag = "R3 full close length";
    @(posedge clk);
    @(negedge clk);
    rx_valid = 1'b0; rx_crc_err = 1'b0; rx_ovr_err = 1'b0; rx_cd_lost = 1'b0; hunt = 1'b0;
    chk(mem_we == acc, bsy ? "R8 dropped byte write" : "R9 write strobe", int'(mem_we), int'(acc));
    if (acc) begin
      chk(int'(mem_addr) == eaddr, "R9 write address", int'(mem_addr), eaddr);
      chk(int'(mem_wdata) == (d & 255), "R9 write data", int'(mem_wdata), d & 255);
    end
    chk(st_we == cl, bsy ? "R8 no close while busy" : "R5 write-back strobe", int'(st_we), int'(cl));
    chk(irq == (cl && m_i[idx] != 0 && irq_en), "R6 interrupt", int'(irq),
        int'(cl && m_i[idx] != 0 && irq_en));
    if (cl) begin
      chk(int'(st_idx) == idx, "R5 write-back index", int'(st_idx), idx);
      chk(int'(st_word) == wexp, "R5 status word", int'(st_word), wexp);
      chk(int'(st_len) == nxt, ctag, int'(st_len), nxt);
      m_e[idx] = 0;
      m_cnt = 0;
      m_idx = (m_w[idx] != 0 || idx == 3) ? 0 : idx + 1;
    end else begin
      m_cnt = nxt;
    end
  endtask

  task automatic arm_all(input int wrap_idx);
    for (int k = 0; k < 4; k++)
      bd_write(k, 1, k & 1, (k == wrap_idx) ? 1 : 0, (k != 1) ? 1 : 0, 'h100 + k * 'h1000);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    for (int k = 0; k < 4; k++) begin
      m_e[k] = 0; m_x[k] = 0; m_w[k] = 0; m_i[k] = 0; m_ptr[k] = 0;
    end
    // R10: reset state
    chk(busy == 1'b1, "R10 busy after reset", int'(busy), 1);
    chk(st_we == 1'b0, "R10 no write-back after reset", int'(st_we), 0);
    chk(irq == 1'b0, "R10 no interrupt after reset", int'(irq), 0);
    chk(mem_we == 1'b0, "R10 no data write after reset", int'(mem_we), 0);

    // R8: nothing is owned yet, all activity is dropped
    step(1, 'h11, 0, 0, 0, 0);
    step(1, 'h12, 1, 0, 0, 0);
    step(0, 0, 0, 0, 0, 1);

    // Sweep sizes, limits, event kinds and event positions (R1..R7, R9)
    for (int bs = 1; bs <= 4; bs++) begin
      for (int ml = 0; ml <= 5; ml++) begin
        for (int kind = 0; kind <= 4; kind++) begin
          for (int pos = 0; pos <= 5; pos++) begin
            buf_size = 16'(bs);
            max_len  = 16'(ml);
            arm_all(-1);
            for (int c = 0; c < 7; c++) begin
              bit ev;
              ev = (c == pos);
              step(c != 3, bs * 40 + ml * 7 + c * 3 + kind, ev && kind == 1,
                   ev && kind == 2, ev && kind == 3, ev && kind == 4);
            end
            step(0, 0, 0, 0, 0, 1);
          end
        end
      end
    end

    // R7: wrap bit on entry 1 makes the ring 0 -> 1 -> 0
    buf_size = 16'd100; max_len = 16'd0;
    arm_all(1);
    for (int k = 0; k < 3; k++) begin
      if (k == 2) bd_write(0, 1, 0, 0, 1, 'h100);
      step(1, k, 0, 0, 0, 0);
      step(0, 0, 0, 0, 0, 1);
    end

    // R6: global mask suppresses the interrupt
    irq_en = 1'b0;
    arm_all(-1);
    for (int k = 0; k < 4; k++) step(1, k, 0, 1, 0, 0);
    irq_en = 1'b1;

    // R8 then R10: ring exhausted, dropped; re-arm current entry and resume
    for (int k = 0; k < 3; k++) step(1, 'h50 + k, 0, 0, 1, 0);
    bd_write(m_idx, 1, 1, 0, 1, 'hFFFFFE);
    for (int k = 0; k < 4; k++) step(1, 'h60 + k, 0, 0, 0, 0);
    step(0, 0, 0, 0, 0, 1);

    // R9: pointer arithmetic wraps at 24 bits (checked above) and R4 with zero bytes
    bd_write(m_idx, 1, 0, 0, 0, 'h200);
    step(0, 0, 0, 0, 0, 1);

    report();
    $finish;
  end

endmodule